// File: doc/BRIEF.md
# Codec-Side Audio Serial Link Framer

This block is the digital front end of a stereo audio codec that attaches to a host controller over a five-wire time-division serial link. The 24.576 MHz master clock is divided by two to give the 12.288 MHz bit clock, which the block drives back to the controller. The controller marks each 256-bit frame with a frame-sync pulse at 48 kHz. A frame has a 16-bit tag slot, and twelve 20-bit slots follow it. Each slot is carried most significant bit first.

On the downstream frame the block decodes register commands from slots 1 and 2 and issues them as single-cycle strobes on a register-bus master port. It also extracts 16-bit playback samples from slots 3 and 4. On the upstream frame it sends a tag that carries the codec-ready flag and the slot valid bits. It returns the answer to a register read in slots 1 and 2 of the frame after the read. It sends 18-bit capture samples in slots 3 and 4 and drives 0 on every other bit. Outgoing bits change on the rising bit-clock edge and incoming bits are sampled on the falling edge. Only the primary codec role is supported, so the slot layout is fixed.

Top module: `aclink_codec_if`

## Requirements
- R1: `link_bclk_o` is low while `rst_n` is low. After reset it toggles on every `mclk` rising edge, so it runs at half the master clock.
- R2: `link_tx_o` stays 0 during reset and until the first SYNC rising edge. In every upstream frame, bits 96 to 255 (slots 5 to 12) are 0.
- R3: Upstream tag bit 15 carries `codec_rdy_i`, sampled when the frame starts. Tag bits 12 and 11 (capture slots valid) also follow it. Bits 10:0 are 0.
- R4: Upstream slots 3 and 4 carry `cap_l_i` and `cap_r_i` in slot bits 19:2, with bits 1:0 set to 0. The samples are taken when the frame starts. Both slots are 0 when the codec is not ready.
- R5: Upstream frame bit 0 (tag bit 15) is launched on the first bit-clock rising edge after the falling edge at which SYNC is first sampled high. The following bits go out MSB first, one per rising edge.
- R6: A downstream frame with tag bits 15, 14 and 13 all set and slot 1 bit 19 equal to 0 produces exactly one `reg_wr_o` pulse, one `mclk` cycle long. The pulse carries `reg_addr_o` = slot 1 bits 18:12 and `reg_wdata_o` = slot 2 bits 19:4.
- R7: A write command is dropped, with no `reg_wr_o` pulse, when tag bit 15, 14 or 13 is clear.
- R8: A downstream frame with tag bits 15 and 14 set and slot 1 bit 19 equal to 1 produces exactly one `reg_rd_o` pulse, with the index from slot 1 bits 18:12, and no write. If tag bit 14 is clear, there is no read.
- R9: After a read, the next upstream frame sets tag bits 14 and 13. Its slot 1 holds {0, index, 12 zeros} and its slot 2 holds {read data, 4 zeros}. A frame that follows one with no read has tag bits 14 and 13 clear and slots 1 and 2 set to 0.
- R10: When tag bits 15 and 12 are set, `play_l_o` takes slot 3 bits 19:4 with one `play_l_vld_o` pulse. Tag bits 15 and 11 do the same for slot 4 into `play_r_o` with `play_r_vld_o`. With the valid bit clear, there is no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | 24.576 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_bclk_o | output | 1 | Bit clock driven to the controller (mclk/2) |
| link_sync_i | input | 1 | Frame sync from the controller |
| link_rx_i | input | 1 | Downstream serial data (controller to codec) |
| link_tx_o | output | 1 | Upstream serial data (codec to controller) |
| codec_rdy_i | input | 1 | Codec ready indication placed in tag bit 15 |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_addr_o | output | 7 | Register index for read or write |
| reg_wdata_o | output | 16 | Register write data |
| reg_rdata_i | input | 16 | Register read data, valid in the cycle of `reg_rd_o` |
| cap_l_i | input | 18 | Left capture sample |
| cap_r_i | input | 18 | Right capture sample |
| play_l_o | output | 16 | Left playback sample |
| play_r_o | output | 16 | Right playback sample |
| play_l_vld_o | output | 1 | Left playback sample strobe |
| play_r_vld_o | output | 1 | Right playback sample strobe |

## Verification
The bench aims at three corner cases:
- Write commands with exactly one of the three required tag bits cleared. A design that tested only the frame-valid bit would corrupt registers here.
- Read responses that must appear in the frame after the read and be gone in the frame after that. A design that answered a frame early, or never cleared its pending flag, would echo stale indices.
- Exact bit alignment of the upstream frame against SYNC, together with zero stuffing after slot 4. An off-by-one in the launch edge shifts every captured field, and a missing clear leaks shifted data into slots 5 to 12.

Random frames mix reads, writes, partial tag sets, PCM valid bits and the codec-ready flag. Every field is compared against a bench model of the register file.

// File: rtl/aclk_pkg.sv
`timescale 1ns/1ps
package aclk_pkg;
  // Number of tag bits that carry meaning: frame valid plus slots 1..4 valid
  localparam int VLD_N    = 5;
  localparam int VB_FRAME = 4;
  localparam int VB_S1    = 3;
  localparam int VB_S2    = 2;
  localparam int VB_S3    = 1;
  localparam int VB_S4    = 0;

  typedef logic [VLD_N-1:0] tag_vld_t;
endpackage

// File: rtl/aclk_bitclk_gen.sv
`timescale 1ns/1ps
module aclk_bitclk_gen (
  input  logic clk,
  input  logic rst_n,
  output logic bclk_o,
  output logic rise_en_o,
  output logic fall_en_o
);
  logic bclk_q;
  logic bclk_d;

  always_comb begin
    bclk_d = ~bclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk_d;
  end

  // The edge that takes bclk high is the launch edge, the one that takes it low samples
  assign bclk_o    = bclk_q;
  assign rise_en_o = ~bclk_q;
  assign fall_en_o = bclk_q;
endmodule

// File: rtl/aclk_rx_deframer.sv
`timescale 1ns/1ps
module aclk_rx_deframer
  import aclk_pkg::*;
#(
  parameter int TAG_W      = 16,
  parameter int SLOT_W     = 20,
  parameter int FRAME_BITS = 256,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int PLAY_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_en,
  input  logic              sync_i,
  input  logic              ser_i,
  output logic              sof_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [PLAY_W-1:0] play_l_o,
  output logic [PLAY_W-1:0] play_r_o,
  output logic              play_l_vld_o,
  output logic              play_r_vld_o
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] END_TAG  = CNT_W'(TAG_W - 1);
  localparam logic [CNT_W-1:0] END_S1   = CNT_W'(TAG_W + SLOT_W - 1);
  localparam logic [CNT_W-1:0] END_S2   = CNT_W'(TAG_W + 2*SLOT_W - 1);
  localparam logic [CNT_W-1:0] END_S3   = CNT_W'(TAG_W + 3*SLOT_W - 1);
  localparam logic [CNT_W-1:0] END_S4   = CNT_W'(TAG_W + 4*SLOT_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d, pos;
  logic              sync_q, sync_d, sync_rise;
  logic [SLOT_W-2:0] sh_q, sh_d;
  logic [SLOT_W-1:0] word;
  tag_vld_t          vld_q, vld_d;
  logic              cmd_rd_q, cmd_rd_d;
  logic [ADDR_W-1:0] cmd_idx_q, cmd_idx_d;
  logic              sof_q, sof_d;
  logic              wr_q, wr_d, rd_q, rd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [PLAY_W-1:0] pl_q, pl_d, pr_q, pr_d;
  logic              plv_q, plv_d, prv_q, prv_d;

  always_comb begin
    sync_rise = sync_i & ~sync_q;
    if (sync_rise)             pos = '0;
    else if (cnt_q == CNT_LAST) pos = CNT_LAST;
    else                        pos = cnt_q + 1'b1;
    word = {sh_q, ser_i};

    cnt_d     = cnt_q;
    sync_d    = sync_q;
    sh_d      = sh_q;
    vld_d     = vld_q;
    cmd_rd_d  = cmd_rd_q;
    cmd_idx_d = cmd_idx_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    pl_d      = pl_q;
    pr_d      = pr_q;
    sof_d     = 1'b0;
    wr_d      = 1'b0;
    rd_d      = 1'b0;
    plv_d     = 1'b0;
    prv_d     = 1'b0;

    if (fall_en) begin
      sync_d = sync_i;
      cnt_d  = pos;
      sh_d   = word[SLOT_W-2:0];
      sof_d  = sync_rise;

      if (pos == END_TAG) begin
        vld_d = word[TAG_W-1 -: VLD_N];
      end

      if (pos == END_S1) begin
        cmd_rd_d  = word[SLOT_W-1];
        cmd_idx_d = word[SLOT_W-2 -: ADDR_W];
        if (vld_q[VB_FRAME] && vld_q[VB_S1] && word[SLOT_W-1]) begin
          rd_d   = 1'b1;
          addr_d = word[SLOT_W-2 -: ADDR_W];
        end
      end

      if (pos == END_S2) begin
        if (vld_q[VB_FRAME] && vld_q[VB_S1] && vld_q[VB_S2] && !cmd_rd_q) begin
          wr_d    = 1'b1;
          addr_d  = cmd_idx_q;
          wdata_d = word[SLOT_W-1 -: DATA_W];
        end
      end

      if (pos == END_S3 && vld_q[VB_FRAME] && vld_q[VB_S3]) begin
        plv_d = 1'b1;
        pl_d  = word[SLOT_W-1 -: PLAY_W];
      end

      if (pos == END_S4 && vld_q[VB_FRAME] && vld_q[VB_S4]) begin
        prv_d = 1'b1;
        pr_d  = word[SLOT_W-1 -: PLAY_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= CNT_LAST;
      sync_q    <= 1'b0;
      sh_q      <= '0;
      vld_q     <= '0;
      cmd_rd_q  <= 1'b0;
      cmd_idx_q <= '0;
      sof_q     <= 1'b0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      pl_q      <= '0;
      pr_q      <= '0;
      plv_q     <= 1'b0;
      prv_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      sync_q    <= sync_d;
      sh_q      <= sh_d;
      vld_q     <= vld_d;
      cmd_rd_q  <= cmd_rd_d;
      cmd_idx_q <= cmd_idx_d;
      sof_q     <= sof_d;
      wr_q      <= wr_d;
      rd_q      <= rd_d;
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
      pl_q      <= pl_d;
      pr_q      <= pr_d;
      plv_q     <= plv_d;
      prv_q     <= prv_d;
    end
  end

  assign sof_o        = sof_q;
  assign wr_o         = wr_q;
  assign rd_o         = rd_q;
  assign addr_o       = addr_q;
  assign wdata_o      = wdata_q;
  assign play_l_o     = pl_q;
  assign play_r_o     = pr_q;
  assign play_l_vld_o = plv_q;
  assign play_r_vld_o = prv_q;
endmodule

// File: rtl/aclk_tx_framer.sv
`timescale 1ns/1ps
module aclk_tx_framer #(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int CAP_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_en,
  input  logic              sof_i,
  input  logic              rdy_i,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_idx_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [CAP_W-1:0]  cap_l_i,
  input  logic [CAP_W-1:0]  cap_r_i,
  output logic              ser_o
);
  // Only the tag and slots 1..4 carry data; later bits are shifted-in zeros
  localparam int NSLOT = 4;
  localparam int TX_W  = TAG_W + NSLOT*SLOT_W;

  logic [TX_W-1:0]   sr_q, sr_d, frame;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [TAG_W-1:0]  tag;
  logic [SLOT_W-1:0] slot [NSLOT];
  logic              load;

  always_comb begin
    tag          = '0;
    tag[TAG_W-1] = rdy_i;
    tag[TAG_W-2] = pend_q;
    tag[TAG_W-3] = pend_q;
    tag[TAG_W-4] = rdy_i;
    tag[TAG_W-5] = rdy_i;
    for (int s = 0; s < NSLOT; s++) slot[s] = '0;
    if (pend_q) begin
      slot[0][SLOT_W-2 -: ADDR_W] = idx_q;
      slot[1][SLOT_W-1 -: DATA_W] = data_q;
    end
    if (rdy_i) begin
      slot[2][SLOT_W-1 -: CAP_W] = cap_l_i;
      slot[3][SLOT_W-1 -: CAP_W] = cap_r_i;
    end
    frame = {tag, slot[0], slot[1], slot[2], slot[3]};
  end

  always_comb begin
    load = rise_en & sof_i;
    if (load)         sr_d = frame;
    else if (rise_en) sr_d = {sr_q[TX_W-2:0], 1'b0};
    else              sr_d = sr_q;

    pend_d = pend_q;
    idx_d  = idx_q;
    data_d = data_q;
    if (rd_stb_i) begin
      pend_d = 1'b1;
      idx_d  = rd_idx_i;
      data_d = rd_data_i;
    end else if (load) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      pend_q <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      sr_q   <= sr_d;
      pend_q <= pend_d;
      idx_q  <= idx_d;
      data_q <= data_d;
    end
  end

  assign ser_o = sr_q[TX_W-1];
endmodule

// File: rtl/aclink_codec_if.sv
`timescale 1ns/1ps
module aclink_codec_if #(
  parameter int TAG_W      = 16,
  parameter int SLOT_W     = 20,
  parameter int FRAME_BITS = 256,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int CAP_W      = 18,
  parameter int PLAY_W     = 16
) (
  input  logic              mclk,
  input  logic              rst_n,
  output logic              link_bclk_o,
  input  logic              link_sync_i,
  input  logic              link_rx_i,
  output logic              link_tx_o,
  input  logic              codec_rdy_i,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic [CAP_W-1:0]  cap_l_i,
  input  logic [CAP_W-1:0]  cap_r_i,
  output logic [PLAY_W-1:0] play_l_o,
  output logic [PLAY_W-1:0] play_r_o,
  output logic              play_l_vld_o,
  output logic              play_r_vld_o
);
  logic rise_en, fall_en, sof;

  aclk_bitclk_gen u_bclk (
    .clk       (mclk),
    .rst_n     (rst_n),
    .bclk_o    (link_bclk_o),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en)
  );

  aclk_rx_deframer #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .FRAME_BITS(FRAME_BITS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PLAY_W(PLAY_W)
  ) u_rx (
    .clk          (mclk),
    .rst_n        (rst_n),
    .fall_en      (fall_en),
    .sync_i       (link_sync_i),
    .ser_i        (link_rx_i),
    .sof_o        (sof),
    .wr_o         (reg_wr_o),
    .rd_o         (reg_rd_o),
    .addr_o       (reg_addr_o),
    .wdata_o      (reg_wdata_o),
    .play_l_o     (play_l_o),
    .play_r_o     (play_r_o),
    .play_l_vld_o (play_l_vld_o),
    .play_r_vld_o (play_r_vld_o)
  );

  // Read data is taken in the cycle the read strobe is high
  aclk_tx_framer #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .CAP_W(CAP_W)
  ) u_tx (
    .clk       (mclk),
    .rst_n     (rst_n),
    .rise_en   (rise_en),
    .sof_i     (sof),
    .rdy_i     (codec_rdy_i),
    .rd_stb_i  (reg_rd_o),
    .rd_idx_i  (reg_addr_o),
    .rd_data_i (reg_rdata_i),
    .cap_l_i   (cap_l_i),
    .cap_r_i   (cap_r_i),
    .ser_o     (link_tx_o)
  );
endmodule

// File: rtl/aclk_codec_chk.sv
`timescale 1ns/1ps
module aclk_codec_chk (
  input logic mclk,
  input logic rst_n,
  input logic link_bclk_o,
  input logic link_tx_o,
  input logic reg_wr_o,
  input logic reg_rd_o,
  input logic play_l_vld_o,
  input logic play_r_vld_o
);
  a_r1_bclk_falls: assert property (@(posedge mclk) disable iff (!rst_n)
    link_bclk_o |=> !link_bclk_o);
  a_r1_bclk_rises: assert property (@(posedge mclk) disable iff (!rst_n)
    !link_bclk_o |=> link_bclk_o);
  a_r5_tx_on_rise: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(link_tx_o) |-> $rose(link_bclk_o));
  a_r6_wr_after_fall: assert property (@(posedge mclk) disable iff (!rst_n)
    reg_wr_o |-> $fell(link_bclk_o));
  a_r6_wr_single: assert property (@(posedge mclk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);
  a_r8_rd_single: assert property (@(posedge mclk) disable iff (!rst_n)
    reg_rd_o |=> !reg_rd_o);
  a_r8_rd_not_wr: assert property (@(posedge mclk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));
  a_r10_vld_after_fall: assert property (@(posedge mclk) disable iff (!rst_n)
    (play_l_vld_o || play_r_vld_o) |-> $fell(link_bclk_o));
endmodule

bind aclink_codec_if aclk_codec_chk u_chk (
  .mclk         (mclk),
  .rst_n        (rst_n),
  .link_bclk_o  (link_bclk_o),
  .link_tx_o    (link_tx_o),
  .reg_wr_o     (reg_wr_o),
  .reg_rd_o     (reg_rd_o),
  .play_l_vld_o (play_l_vld_o),
  .play_r_vld_o (play_r_vld_o)
);

// File: tb/aclink_codec_if_tb.sv
`timescale 1ns/1ps
module aclink_codec_if_tb;
  logic        mclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_bclk_o, link_tx_o;
  logic        link_sync_i = 1'b0, link_rx_i = 1'b0;
  logic        codec_rdy_i = 1'b0;
  logic        reg_wr_o, reg_rd_o;
  logic [6:0]  reg_addr_o;
  logic [15:0] reg_wdata_o, reg_rdata_i;
  logic [17:0] cap_l_i = '0, cap_r_i = '0;
  logic [15:0] play_l_o, play_r_o;
  logic        play_l_vld_o, play_r_vld_o;

  always #2.5 mclk = ~mclk;

  aclink_codec_if u_dut (
    .mclk(mclk), .rst_n(rst_n), .link_bclk_o(link_bclk_o),
    .link_sync_i(link_sync_i), .link_rx_i(link_rx_i), .link_tx_o(link_tx_o),
    .codec_rdy_i(codec_rdy_i), .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i),
    .cap_l_i(cap_l_i), .cap_r_i(cap_r_i), .play_l_o(play_l_o), .play_r_o(play_r_o),
    .play_l_vld_o(play_l_vld_o), .play_r_vld_o(play_r_vld_o)
  );

  logic [15:0] bmem [128];
  logic [15:0] emem [128];
  assign reg_rdata_i = bmem[reg_addr_o];

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0, l_cnt = 0, r_cnt = 0;
  logic [15:0] last_l = '0, last_r = '0;
  logic [255:0] ifr;
  logic        exp_pend = 1'b0;
  logic [6:0]  exp_idx = '0;
  logic [15:0] exp_data = '0;

  always @(negedge mclk) begin
    if (rst_n) begin
      if (reg_wr_o) begin bmem[reg_addr_o] = reg_wdata_o; wr_cnt++; end
      if (reg_rd_o) rd_cnt++;
      if (play_l_vld_o) begin l_cnt++; last_l = play_l_o; end
      if (play_r_vld_o) begin r_cnt++; last_r = play_r_o; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] exp_up(input logic rdy, input logic pend, input logic [6:0] idx,
                                         input logic [15:0] dat, input logic [17:0] cl, input logic [17:0] cr);
    logic [15:0] t;
    logic [19:0] s1, s2, s3, s4;
    t  = {rdy, pend, pend, rdy, rdy, 11'b0};
    s1 = pend ? {1'b0, idx, 12'b0} : 20'b0;
    s2 = pend ? {dat, 4'b0} : 20'b0;
    s3 = rdy ? {cl, 2'b0} : 20'b0;
    s4 = rdy ? {cr, 2'b0} : 20'b0;
    return {t, s1, s2, s3, s4};
  endfunction

  task automatic run_frame(input logic [255:0] ofr);
    ifr = '0;
    for (int k = 0; k < 256; k++) begin
      @(posedge link_bclk_o); #1;
      link_sync_i = (k < 16);
      link_rx_i   = ofr[255-k];
      @(negedge link_bclk_o); #1;
      if (k > 0) ifr[256-k] = link_tx_o;
    end
  endtask

  task automatic frame_chk(input bit fv, input bit v1, input bit v2, input bit v3, input bit v4,
                           input bit rd, input logic [6:0] idx, input logic [15:0] wd,
                           input logic [15:0] pl, input logic [15:0] pr, input string req);
    logic [95:0] e;
    int w0, r0, l0, q0;
    bit ew, er;
    e  = exp_up(codec_rdy_i, exp_pend, exp_idx, exp_data, cap_l_i, cap_r_i);
    w0 = wr_cnt; r0 = rd_cnt; l0 = l_cnt; q0 = r_cnt;
    run_frame({fv, v1, v2, v3, v4, 11'h2a5, rd, idx, 12'h3c1, wd, 4'h9, pl, 4'h6, pr, 4'hf, 160'b0});
    chk(ifr[255:160] == e, req, 256'(ifr[255:160]), 256'(e));
    chk(ifr[159:0] == '0, "R2 zero stuffing", 256'(ifr[159:0]), 256'(0));
    ew = fv & v1 & v2 & !rd;
    er = fv & v1 & rd;
    chk((wr_cnt - w0) == int'(ew), "R6/R7 write count", 256'(wr_cnt - w0), 256'(ew));
    if (ew) begin
      emem[idx] = wd;
      chk(bmem[idx] == wd, "R6 write data", 256'(bmem[idx]), 256'(wd));
    end
    chk((rd_cnt - r0) == int'(er), "R8 read count", 256'(rd_cnt - r0), 256'(er));
    exp_pend = er;
    if (er) begin exp_idx = idx; exp_data = emem[idx]; end
    chk((l_cnt - l0) == int'(fv & v3), "R10 left strobe", 256'(l_cnt - l0), 256'(fv & v3));
    chk((r_cnt - q0) == int'(fv & v4), "R10 right strobe", 256'(r_cnt - q0), 256'(fv & v4));
    if (fv & v3) chk(last_l == pl, "R10 left data", 256'(last_l), 256'(pl));
    if (fv & v4) chk(last_r == pr, "R10 right data", 256'(last_r), 256'(pr));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge mclk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed_sink;
    logic prev;
    bit ok;
    seed_sink = $urandom(32'd2718);
    for (int i = 0; i < 128; i++) begin
      bmem[i] = 16'(i * 16'h0101) ^ 16'h5a5a;
      emem[i] = bmem[i];
    end

    // R1 / R2: reset state
    repeat (4) @(negedge mclk);
    chk(link_bclk_o == 1'b0 && link_tx_o == 1'b0 && !reg_wr_o && !reg_rd_o
        && !play_l_vld_o && !play_r_vld_o, "R1 reset state",
        256'({link_bclk_o, link_tx_o, reg_wr_o, reg_rd_o}), 256'(0));
    rst_n = 1'b1;

    // R1: toggles each master clock cycle
    @(negedge mclk); prev = link_bclk_o; ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge mclk);
      if (link_bclk_o == prev) ok = 1'b0;
      prev = link_bclk_o;
    end
    chk(ok, "R1 half-rate bit clock", 256'(ok), 256'(1));

    // R2: silent before first sync
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin @(negedge mclk); if (link_tx_o) ok = 1'b0; end
    chk(ok, "R2 idle before sync", 256'(ok), 256'(1));

    // R3: not ready
    frame_chk(0, 0, 0, 0, 0, 0, 7'h00, 16'h0000, 16'h0, 16'h0, "R3 R5 not ready frame");
    codec_rdy_i = 1'b1;
    cap_l_i = 18'h2abcd; cap_r_i = 18'h15432;
    frame_chk(1, 0, 0, 0, 0, 0, 7'h00, 16'h0000, 16'h0, 16'h0, "R3 R4 R5 ready frame");
    // R6 valid write, then R7 partial tags
    frame_chk(1, 1, 1, 0, 0, 0, 7'h12, 16'hbeef, 16'h0, 16'h0, "R6 write frame");
    frame_chk(1, 1, 0, 0, 0, 0, 7'h12, 16'h1111, 16'h0, 16'h0, "R7 slot2 invalid");
    frame_chk(0, 1, 1, 0, 0, 0, 7'h12, 16'h2222, 16'h0, 16'h0, "R7 frame invalid");
    frame_chk(1, 0, 1, 0, 0, 0, 7'h12, 16'h3333, 16'h0, 16'h0, "R7 slot1 invalid");
    // R8 / R9 read and response
    frame_chk(1, 1, 0, 0, 0, 1, 7'h12, 16'h0000, 16'h0, 16'h0, "R8 read frame");
    frame_chk(1, 0, 0, 0, 0, 0, 7'h00, 16'h0000, 16'h0, 16'h0, "R9 response frame");
    frame_chk(1, 0, 0, 0, 0, 0, 7'h00, 16'h0000, 16'h0, 16'h0, "R9 cleared frame");
    frame_chk(1, 0, 1, 0, 0, 1, 7'h33, 16'h0000, 16'h0, 16'h0, "R8 read without slot1 valid");
    // R10 playback
    frame_chk(1, 0, 0, 1, 0, 0, 7'h00, 16'h0000, 16'hc0de, 16'h7777, "R10 left only");
    frame_chk(1, 0, 0, 1, 1, 0, 7'h00, 16'h0000, 16'h8001, 16'h7ffe, "R10 both");
    frame_chk(0, 0, 0, 1, 1, 0, 7'h00, 16'h0000, 16'h1234, 16'h4321, "R10 frame invalid");
    // Random frames
    for (int n = 0; n < 30; n++) begin
      bit fv, v1, v2, v3, v4, rd;
      codec_rdy_i = ($urandom % 5) != 0;
      cap_l_i = 18'($urandom); cap_r_i = 18'($urandom);
      fv = ($urandom % 6) != 0;
      v1 = ($urandom % 3) != 0; v2 = ($urandom % 3) != 0;
      v3 = $urandom % 2; v4 = $urandom % 2; rd = $urandom % 2;
      frame_chk(fv, v1, v2, v3, v4, rd, 7'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                "R3 R4 R9 random frame");
    end
    finish_run();
  end
endmodule